// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the bit-timing layer of an I2C master. It takes one command at a time over a valid/ready handshake and turns it into open-drain activity on SCL and SDA. The six command kinds are a bus clear, START, STOP, a byte write that reports the acknowledge the slave returned, a byte read that ends with an acknowledge level chosen by the caller, and a no-op. When a command has finished, `rsp_done` pulses for one cycle. Transaction sequencing (address phases, repeated starts, retries) belongs to the logic above this block.

Each command is built from quarter-bit slots. Every slot holds for `quarter_div` clock cycles, and that value is captured when the command is accepted. The engine only ever pulls a line low or releases it: `scl_oe` and `sda_oe` high mean the line is pulled low. SDA is sensed through a two-flop synchronizer. With a 100 MHz clock, a quarter of 500 cycles gives 5 us slots, which is roughly a 50 kHz bus. Clock stretching, arbitration and slave operation are not handled.

Top module: `i2c_bit_engine`

## Requirements
- R1: While reset is held and right after it, `scl_oe` = 0, `sda_oe` = 0, `rsp_done` = 0 and `cmd_ready` = 1.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 until the command completes, and `cmd_valid` has no effect during that time. Each accepted command gives exactly one `rsp_done` pulse, one cycle wide.
- R3: `rsp_done` is high in the cycle that begins N·Q cycles after the accepting edge. Q is the captured quarter length. N is 40 for bus clear, 4 for START, 4 for STOP, 37 for write, 29 for read and 1 for no-op.
- R4: `cmd_op` encodings are 1 = bus clear, 2 = START, 3 = STOP, 4 = write, 5 = read. The codes 0, 6 and 7 are no-ops: they leave `scl_oe` and `sda_oe` unchanged and take one quarter.
- R5: START releases SDA, then releases SCL, then pulls SDA low while SCL is high, with a quarter between steps and a quarter before the first step. It ends with SCL released and SDA pulled low.
- R6: STOP pulls SCL low, pulls SDA low, releases SCL, then releases SDA while SCL is high. It ends with both lines released.
- R7: Write sends `cmd_wdata` MSB first on eight SCL pulses and releases SDA for a ninth pulse. `rsp_nack` takes the SDA level sampled late in the ninth SCL-high time, where 0 means acknowledged.
- R8: Read releases SDA and shifts in eight bits MSB first, sampling one quarter into each SCL-high time. It then drives `cmd_ack_lvl` on the ninth pulse. `rsp_rdata` holds the byte when `rsp_done` rises.
- R9: Bus clear gives nine SCL low/high pulses, each half two quarters long, with SDA released. A STOP follows, for ten SCL rising edges in total.
- R10: The quarter length is captured at acceptance. Changing `quarter_div` during a command has no effect on it, and a value of 0 is treated as 1.
- R11: Outside START, STOP and bus clear, `sda_oe` changes only when `scl_oe` was 1 on the previous cycle, so writes and reads never create a START or STOP condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quarter_div | input | DIV_W | Clock cycles per quarter-bit slot |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 3 | Command code |
| cmd_wdata | input | 8 | Byte to write |
| cmd_ack_lvl | input | 1 | Level driven on the read acknowledge pulse |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| rsp_nack | output | 1 | Last sampled write acknowledge (1 = not acknowledged) |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
Every result of this block appears an exact number of cycles after acceptance: N·Q cycles with N taken from R3. The data outputs are valid in that same cycle. The driver records the accepting cycle with each expected item. The monitor samples on falling clock edges, and when `rsp_done` appears it compares the elapsed cycle count, the read byte and the acknowledge against the item at the head of the queue. An open-drain bus model logs the SDA level at every SCL rise, together with any START or STOP condition, so the bench can check bit order and line sequencing after each command.

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] quarter_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_wdata,
  input  logic             cmd_ack_lvl,
  output logic             rsp_done,
  output logic [7:0]       rsp_rdata,
  output logic             rsp_nack,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  localparam logic [2:0] OP_CLR = 3'd1, OP_START = 3'd2, OP_STOP = 3'd3,
                         OP_WR = 3'd4, OP_RD = 3'd5;
  localparam int SLOT_W = 6;
  localparam int NBITS = 8;
  localparam logic [SLOT_W-1:0] WR_END  = SLOT_W'((NBITS + 1) * 4);
  localparam logic [SLOT_W-1:0] RD_END  = SLOT_W'(NBITS * 3);
  localparam logic [SLOT_W-1:0] CLR_END = SLOT_W'(9 * 4);
  localparam logic [SLOT_W-1:0] THREE   = SLOT_W'(3);

  logic [1:0]        sda_sync;
  logic              busy;
  logic [2:0]        op_q;
  logic [7:0]        sh;
  logic              ack_q;
  logic [DIV_W-1:0]  div_q, qcnt;
  logic [SLOT_W-1:0] slot, last_slot;
  logic [SLOT_W-1:0] rd_bit, rd_ph, rd_ack;
  logic [3:0]        wr_bit;
  logic              slot_start, slot_end;
  logic              set_scl, scl_hi, set_sda, sda_hi;
  logic              smp_wr, smp_rd, shift_wr, rd_rel;
  logic              stop_act;

  assign cmd_ready  = !busy;
  assign slot_start = busy && (qcnt == '0);
  assign slot_end   = busy && (qcnt == div_q - DIV_W'(1));
  assign wr_bit     = slot[5:2];
  assign rd_bit     = slot / THREE;
  assign rd_ph      = slot - rd_bit * THREE;
  assign rd_ack     = slot - RD_END;

  always_comb begin
    case (op_q)
      OP_CLR:   last_slot = CLR_END + THREE;
      OP_START: last_slot = THREE;
      OP_STOP:  last_slot = THREE;
      OP_WR:    last_slot = WR_END;
      OP_RD:    last_slot = RD_END + SLOT_W'(4);
      default:  last_slot = '0;
    endcase
  end

  always_comb begin
    set_scl = 1'b0; scl_hi = 1'b1; set_sda = 1'b0; sda_hi = 1'b1;
    smp_wr = 1'b0; smp_rd = 1'b0; shift_wr = 1'b0; rd_rel = 1'b0;
    stop_act = 1'b0;
    case (op_q)
      OP_START: begin
        case (slot[1:0])
          2'd1: begin set_sda = 1'b1; sda_hi = 1'b1; end
          2'd2: begin set_scl = 1'b1; scl_hi = 1'b1; end
          2'd3: begin set_sda = 1'b1; sda_hi = 1'b0; end
          default: ;
        endcase
      end
      OP_STOP: stop_act = 1'b1;
      OP_CLR: begin
        if (slot < CLR_END) begin
          set_scl = 1'b1;
          scl_hi  = slot[1];
          if (slot == '0) begin set_sda = 1'b1; sda_hi = 1'b1; end
        end else begin
          stop_act = 1'b1;
        end
      end
      OP_WR: begin
        if (slot < WR_END) begin
          case (slot[1:0])
            2'd0: begin set_scl = 1'b1; scl_hi = 1'b0; end
            2'd1: begin set_sda = 1'b1; sda_hi = (wr_bit == 4'(NBITS)) ? 1'b1 : sh[7]; end
            2'd2: begin set_scl = 1'b1; scl_hi = 1'b1; end
            default: begin
              shift_wr = (wr_bit < 4'(NBITS));
              smp_wr   = (wr_bit == 4'(NBITS));
            end
          endcase
        end else begin
          set_scl = 1'b1; scl_hi = 1'b0;
        end
      end
      OP_RD: begin
        if (slot < RD_END) begin
          rd_rel = 1'b1;
          if (rd_ph == '0) begin
            set_scl = 1'b1; scl_hi = 1'b0;
          end else if (rd_ph == SLOT_W'(1)) begin
            set_scl = 1'b1; scl_hi = 1'b1; smp_rd = 1'b1;
          end
        end else begin
          case (rd_ack)
            SLOT_W'(0): begin set_scl = 1'b1; scl_hi = 1'b0; end
            SLOT_W'(1): begin set_sda = 1'b1; sda_hi = ack_q; end
            SLOT_W'(2): begin set_scl = 1'b1; scl_hi = 1'b1; end
            SLOT_W'(4): begin set_scl = 1'b1; scl_hi = 1'b0; end
            default: ;
          endcase
        end
      end
      default: ;
    endcase
    // CLR_END is a multiple of four, so slot[1:0] is also the stop step index
    if (stop_act) begin
      case (slot[1:0])
        2'd0: begin set_scl = 1'b1; scl_hi = 1'b0; end
        2'd1: begin set_sda = 1'b1; sda_hi = 1'b0; end
        2'd2: begin set_scl = 1'b1; scl_hi = 1'b1; end
        default: begin set_sda = 1'b1; sda_hi = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_sync  <= 2'b11;
      busy      <= 1'b0;
      op_q      <= '0;
      sh        <= '0;
      ack_q     <= 1'b1;
      div_q     <= DIV_W'(1);
      qcnt      <= '0;
      slot      <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      rsp_nack  <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      sda_sync <= {sda_sync[0], sda_in};
      rsp_done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy  <= 1'b1;
          op_q  <= cmd_op;
          sh    <= cmd_wdata;
          ack_q <= cmd_ack_lvl;
          div_q <= (quarter_div == '0) ? DIV_W'(1) : quarter_div;
          qcnt  <= '0;
          slot  <= '0;
        end
      end else begin
        if (slot_start && set_scl) scl_oe <= !scl_hi;
        if (slot_start && set_sda) sda_oe <= !sda_hi;
        if (rd_rel && scl_oe) sda_oe <= 1'b0;
        if (slot_end) begin
          qcnt <= '0;
          if (shift_wr) sh <= {sh[6:0], 1'b0};
          if (smp_wr) rsp_nack <= sda_sync[1];
          if (smp_rd) rsp_rdata <= {rsp_rdata[6:0], sda_sync[1]};
          if (slot == last_slot) begin
            busy     <= 1'b0;
            rsp_done <= 1'b1;
          end else begin
            slot <= slot + SLOT_W'(1);
          end
        end else begin
          qcnt <= qcnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

module i2c_bit_engine_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             rsp_done,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             busy,
  input logic [2:0]       op_q,
  input logic [DIV_W-1:0] div_q
);
  localparam logic [2:0] K_CLR = 3'd1, K_START = 3'd2, K_STOP = 3'd3;

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_div_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));

  assert_sda_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && $past(op_q) != K_START && $past(op_q) != K_STOP
     && $past(op_q) != K_CLR) |-> $past(scl_oe));

  assert_start_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && op_q == K_START) |-> (!scl_oe && sda_oe));

  assert_stop_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && op_q == K_STOP) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_bit_engine i2c_bit_engine_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_done(rsp_done), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
  .op_q(op_q), .div_q(div_q)
);

// File: tb/i2c_bit_engine_tb_top.sv
module i2c_bit_engine_tb_top;
  localparam int DIV_W = 16;
  localparam logic [2:0] C_NOP = 3'd0, C_CLR = 3'd1, C_START = 3'd2, C_STOP = 3'd3,
                         C_WR = 3'd4, C_RD = 3'd5, C_NOP7 = 3'd6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic [DIV_W-1:0] quarter_div;
  logic             cmd_valid, cmd_ready, cmd_ack_lvl;
  logic [2:0]       cmd_op;
  logic [7:0]       cmd_wdata, rsp_rdata;
  logic             rsp_done, rsp_nack, scl_oe, sda_oe, sda_in;

  i2c_bit_engine #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_ack_lvl(cmd_ack_lvl),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_nack(rsp_nack),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // open-drain bus and slave model
  int       mode = 0;
  logic [7:0] pat = '0;
  logic     want_nack = 1'b0;
  int       held = 0, rises = 0, arm_id = 0, seen_id = 0, starts = 0, stops = 0;
  logic     bits[$];
  logic     scl_prev = 1'b1, sda_prev = 1'b1;
  logic     slave_pull, scl_line, sda_line;

  assign slave_pull = (mode == 2) ? (held < 8 && !pat[7 - held]) :
                      (mode == 1) ? (held == 8 && !want_nack) : 1'b0;
  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slave_pull);
  assign sda_in   = sda_line;

  always @(negedge clk) begin
    if (arm_id != seen_id) begin
      seen_id = arm_id; rises = 0; held = 0; bits.delete();
    end else begin
      if (!scl_prev && scl_line) begin rises++; bits.push_back(sda_line); end
      if (scl_prev && !scl_line) held = rises;
      if (scl_prev && scl_line && sda_prev && !sda_line) starts++;
      if (scl_prev && scl_line && !sda_prev && sda_line) stops++;
    end
    scl_prev = scl_line;
    sda_prev = sda_line;
  end

  int checks = 0, fails = 0, dones = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct {
    int         acc;
    int         lat;
    bit         cd;
    logic [7:0] d;
    bit         cn;
    logic       n;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      dones++;
      if (sb.size() == 0) chk(1'b0, "R2 done without command", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc - e.acc == e.lat, {e.tag, " R3 latency"}, cyc - e.acc, e.lat);
        if (e.cd) chk(rsp_rdata == e.d, {e.tag, " read byte"}, rsp_rdata, e.d);
        if (e.cn) chk(rsp_nack == e.n, {e.tag, " ack sample"}, rsp_nack, e.n);
      end
    end
  end

  task automatic arm(int m, logic [7:0] p, logic wn);
    mode = m; pat = p; want_nack = wn; arm_id++;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic issue(logic [2:0] op, logic [7:0] wd, logic ack, int dv, int quarters,
                       bit cd, logic [7:0] d, bit cn, logic n, string tag);
    exp_t e;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_wdata = wd; cmd_ack_lvl = ack; quarter_div = DIV_W'(dv); cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    e.acc = cyc; e.lat = quarters * ((dv == 0) ? 1 : dv);
    e.cd = cd; e.d = d; e.cn = cn; e.n = n; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic settle();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] first_byte();
    logic [7:0] b = '0;
    for (int i = 0; i < 8; i++) b = {b[6:0], (i < bits.size()) ? bits[i] : 1'bx};
    return b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int s0, p0, d0, ready_seen;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_wdata = '0; cmd_ack_lvl = 1'b1;
    quarter_div = DIV_W'(4);
    repeat (4) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
    chk(cmd_ready && !rsp_done, "R1 ready/done in reset", {cmd_ready, rsp_done}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && cmd_ready, "R1 idle after reset", {cmd_ready, scl_oe, sda_oe}, 4);

    // R5 start
    arm(0, '0, 1'b0); s0 = starts;
    issue(C_START, '0, 1'b1, 4, 4, 0, '0, 0, 1'b0, "R5 start");
    settle();
    chk(!scl_oe && sda_oe, "R5 start end state", {scl_oe, sda_oe}, 1);
    chk(starts == s0 + 1, "R5 start condition seen", starts - s0, 1);

    // R7 write acknowledged, R11 no spurious conditions
    s0 = starts; p0 = stops;
    arm(1, '0, 1'b0);
    issue(C_WR, 8'hA5, 1'b1, 4, 37, 0, '0, 1, 1'b0, "R7 write ack");
    settle();
    chk(bits.size() == 9, "R7 nine clocks", bits.size(), 9);
    chk(first_byte() == 8'hA5, "R7 MSB-first bits", first_byte(), 8'hA5);

    // R7 write not acknowledged, other divider
    arm(1, '0, 1'b1);
    issue(C_WR, 8'h3C, 1'b0, 5, 37, 0, '0, 1, 1'b1, "R7 write nack");
    settle();
    chk(first_byte() == 8'h3C, "R7 MSB-first bits 2", first_byte(), 8'h3C);
    chk(bits.size() == 9 && bits[8] == 1'b1, "R7 ninth clock released", bits[8], 1);

    // R8 read with acknowledge
    arm(2, 8'h96, 1'b0);
    issue(C_RD, '0, 1'b0, 4, 29, 1, 8'h96, 0, 1'b0, "R8 read ack");
    settle();
    chk(bits.size() == 9 && bits[8] == 1'b0, "R8 ack level driven 0", bits[8], 0);

    // R8 read ending with not-acknowledge
    arm(2, 8'h5A, 1'b0);
    issue(C_RD, '0, 1'b1, 6, 29, 1, 8'h5A, 0, 1'b0, "R8 read last");
    settle();
    chk(bits.size() == 9 && bits[8] == 1'b1, "R8 ack level driven 1", bits[8], 1);
    chk(starts == s0 && stops == p0, "R11 no condition during data", starts - s0 + stops - p0, 0);

    // R6 stop
    arm(0, '0, 1'b0); p0 = stops;
    issue(C_STOP, '0, 1'b1, 4, 4, 0, '0, 0, 1'b0, "R6 stop");
    settle();
    chk(!scl_oe && !sda_oe, "R6 stop leaves bus released", {scl_oe, sda_oe}, 0);
    chk(stops == p0 + 1, "R6 stop condition seen", stops - p0, 1);

    // R9 bus clear from idle
    arm(0, '0, 1'b0); p0 = stops; s0 = starts;
    issue(C_CLR, '0, 1'b1, 3, 40, 0, '0, 0, 1'b0, "R9 bus clear");
    settle();
    chk(bits.size() == 10, "R9 ten rising edges", bits.size(), 10);
    chk(first_byte() == 8'hFF && bits[8] == 1'b1, "R9 SDA released on pulses", first_byte(), 8'hFF);
    chk(stops == p0 + 1 && starts == s0, "R9 trailing stop", stops - p0, 1);
    chk(!scl_oe && !sda_oe, "R9 bus released", {scl_oe, sda_oe}, 0);

    // R4 no-op codes keep lines as they were
    issue(C_START, '0, 1'b1, 4, 4, 0, '0, 0, 1'b0, "R5 start again");
    settle();
    issue(C_NOP7, '0, 1'b0, 7, 1, 0, '0, 0, 1'b0, "R4 nop code 6");
    settle();
    chk(!scl_oe && sda_oe, "R4 nop keeps lines", {scl_oe, sda_oe}, 1);
    issue(C_NOP, '0, 1'b0, 3, 1, 0, '0, 0, 1'b0, "R4 nop code 0");
    settle();
    chk(!scl_oe && sda_oe, "R4 nop code 0 keeps lines", {scl_oe, sda_oe}, 1);

    // R10 divider captured at acceptance; zero means one
    issue(C_STOP, '0, 1'b1, 6, 4, 0, '0, 0, 1'b0, "R10 captured divider");
    quarter_div = DIV_W'(2);
    settle();
    issue(C_NOP, '0, 1'b0, 0, 1, 0, '0, 0, 1'b0, "R10 zero divider");
    settle();

    // R2 valid ignored while busy
    arm(1, '0, 1'b0); d0 = dones; s0 = starts; ready_seen = 0;
    issue(C_WR, 8'h81, 1'b1, 4, 37, 0, '0, 1, 1'b0, "R2 busy write");
    cmd_op = C_START; cmd_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cmd_ready) ready_seen++;
    end
    cmd_valid = 1'b0;
    settle();
    repeat (10) @(negedge clk);
    chk(ready_seen == 0, "R2 ready low while busy", ready_seen, 0);
    chk(dones == d0 + 1, "R2 single done", dones - d0, 1);
    chk(starts == s0 && first_byte() == 8'h81, "R2 held valid had no effect", first_byte(), 8'h81);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule